// File: doc/BRIEF.md
# Triggered Pulse Train Generator

This block is a counter-driven pulse source. It produces a train of pulses whose high and low phases last a set number of clock cycles. Three separate qualifiers control it. An arm event enables the block, and can come from a software strobe or from a rising edge on a hardware arm pin. A start edge on the gate input then launches the train. When the gate is used as a pause trigger instead, its level can hold the train in place. A train is either finite, emitting a set number of pulses, or continuous, running until a software stop.

A finite train normally leaves the block unarmed when it completes. With retriggering enabled, the block stays armed after completion, so each later start edge replays the whole train. All inputs are assumed synchronous to the clock. Configuration inputs are expected to stay steady while a train runs.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset the block is unarmed, with pulse_out, busy and done all 0. While unarmed, start edges on gate have no effect. Arming takes either a one-cycle sw_arm strobe or a 0-to-1 change of hw_arm. A level already present on hw_arm or gate during reset is not treated as an edge.
- R2: A start edge sampled at clock edge t sets pulse_out to 1 from cycle t+1 for cfg_high_ticks cycles, then to 0 for cfg_low_ticks cycles. This pattern repeats for each pulse. Both tick values must be at least 1.
- R3: With cfg_continuous=0, the train emits exactly cfg_pulse_count pulses, where cfg_pulse_count must be at least 1. In the cycle after the last low phase, busy is 0 and done is 1 for exactly one cycle.
- R4: With cfg_continuous=1, the train repeats until sw_stop is sampled. In the next cycle pulse_out and busy are 0 and done stays 0. The block is then unarmed. sw_stop takes precedence over any arm or start event sampled with it.
- R5: With cfg_retrigger=1, a completed finite train leaves the block armed, and each later start edge restarts the full train. With cfg_retrigger=0, completion leaves the block unarmed, and later start edges do nothing.
- R6: A start edge that arrives while a train is running is ignored. The pulse count and the phase timing are unchanged.
- R7: With cfg_start_pol=1 a start edge is a 0-to-1 change of gate. With cfg_start_pol=0 it is a 1-to-0 change.
- R8: With cfg_pause_en=1, start edges are not used. An arm event starts a continuous train with its first high cycle in the next cycle, whatever the setting of cfg_continuous.
- R9: In pause mode, consider any clock edge where gate differs from cfg_pause_pol. In the following cycle pulse_out keeps its level and the phase counter does not advance. The interrupted phase resumes with the cycles it had left.
- R10: busy is 1 exactly while a train runs. It rises in the cycle after the start and falls when the train completes or stops. pulse_out is never 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_arm | input | 1 | Software arm strobe |
| hw_arm | input | 1 | Hardware arm pin, rising edge arms |
| gate | input | 1 | Start trigger or pause level input |
| sw_stop | input | 1 | Software stop strobe |
| cfg_high_ticks | input | CNT_W | Cycles of the high phase (at least 1) |
| cfg_low_ticks | input | CNT_W | Cycles of the low phase (at least 1) |
| cfg_pulse_count | input | PC_W | Pulses in a finite train (at least 1) |
| cfg_continuous | input | 1 | 1: continuous train, 0: finite train |
| cfg_retrigger | input | 1 | Stay armed after a finite train |
| cfg_start_pol | input | 1 | 1: rising start edge, 0: falling start edge |
| cfg_pause_en | input | 1 | Use gate as pause level instead of start edge |
| cfg_pause_pol | input | 1 | Gate level at which the train runs in pause mode |
| pulse_out | output | 1 | Pulse output |
| busy | output | 1 | Train in progress |
| done | output | 1 | One-cycle flag when a finite train completes |

## Verification
The bench targets several corner cases:
- start edges that reach the gate while the block is unarmed, while a train is running, and after a finite train has completed, both with and without retriggering;
- a hw_arm level that stays high after a stop;
- a stop issued midway through a finite train;
- pause stretches in both polarities;
- the one-cycle phases of the shortest pulse.

Each wrong design fails in a visible way. Double-counting a start edge during a run would produce too many pulses. Missing the retrigger path would leave the block silent after completion. Treating a held arm level as a new arm would restart after a stop. A counter that keeps running during a pause would shorten the interrupted phase. An off-by-one in the phase compare would stretch every pulse.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } gen_state_e;
endpackage

// File: rtl/pgen_edge.sv
module pgen_edge (
    input  logic clk,
    input  logic sig,
    input  logic active_high,
    output logic hit
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        hit    = (sig == active_high) && (prev_q != sig);
    end

    // tracks the input through reset too, so a held level is never an edge
    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end
endmodule

// File: rtl/pgen_phase.sv
module pgen_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic             advance,
    input  logic [CNT_W-1:0] high_ticks,
    input  logic [CNT_W-1:0] low_ticks,
    output logic             level,
    output logic             pulse_end
);
    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] tick;
    } phase_t;

    phase_t ph_d, ph_q;
    logic   high_end;

    assign high_end  = advance && ph_q.level && (ph_q.tick == high_ticks - 1'b1);
    assign pulse_end = advance && !ph_q.level && (ph_q.tick == low_ticks - 1'b1);
    assign level     = ph_q.level;

    always_comb begin
        ph_d = ph_q;
        if (clear) begin
            ph_d = '0;
        end else if (load) begin
            ph_d.level = 1'b1;
            ph_d.tick  = '0;
        end else if (advance) begin
            if (high_end) begin
                ph_d.level = 1'b0;
                ph_d.tick  = '0;
            end else if (pulse_end) begin
                ph_d.level = 1'b1;
                ph_d.tick  = '0;
            end else begin
                ph_d.tick = ph_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= '0;
        else     ph_q <= ph_d;
    end
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
    parameter int CNT_W = 16,
    parameter int PC_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_arm,
    input  logic             hw_arm,
    input  logic             gate,
    input  logic             sw_stop,
    input  logic [CNT_W-1:0] cfg_high_ticks,
    input  logic [CNT_W-1:0] cfg_low_ticks,
    input  logic [PC_W-1:0]  cfg_pulse_count,
    input  logic             cfg_continuous,
    input  logic             cfg_retrigger,
    input  logic             cfg_start_pol,
    input  logic             cfg_pause_en,
    input  logic             cfg_pause_pol,
    output logic             pulse_out,
    output logic             busy,
    output logic             done
);
    import pgen_pkg::*;

    typedef struct packed {
        gen_state_e      state;
        logic [PC_W-1:0] pcnt;
        logic            done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic arm_edge, start_edge;
    logic arm_evt, start_evt, paused, advance, pulse_end, is_last;
    logic clear, load;

    pgen_edge u_arm_edge (
        .clk         (clk),
        .sig         (hw_arm),
        .active_high (1'b1),
        .hit         (arm_edge)
    );

    pgen_edge u_start_edge (
        .clk         (clk),
        .sig         (gate),
        .active_high (cfg_start_pol),
        .hit         (start_edge)
    );

    pgen_phase #(.CNT_W(CNT_W)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .load       (load),
        .advance    (advance),
        .high_ticks (cfg_high_ticks),
        .low_ticks  (cfg_low_ticks),
        .level      (pulse_out),
        .pulse_end  (pulse_end)
    );

    always_comb begin
        arm_evt   = sw_arm || arm_edge;
        start_evt = !cfg_pause_en && start_edge;
        paused    = cfg_pause_en && (gate != cfg_pause_pol);
        advance   = (ctl_q.state == ST_RUN) && !paused;
        is_last   = !cfg_continuous && !cfg_pause_en
                    && (ctl_q.pcnt == cfg_pulse_count - 1'b1);
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        clear      = 1'b0;
        load       = 1'b0;
        if (sw_stop) begin
            ctl_d.state = ST_IDLE;
            clear       = 1'b1;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE: begin
                    if (arm_evt) begin
                        if (cfg_pause_en) begin
                            ctl_d.state = ST_RUN;
                            ctl_d.pcnt  = '0;
                            load        = 1'b1;
                        end else begin
                            ctl_d.state = ST_ARMED;
                        end
                    end
                end
                ST_ARMED: begin
                    if (cfg_pause_en || start_evt) begin
                        ctl_d.state = ST_RUN;
                        ctl_d.pcnt  = '0;
                        load        = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (pulse_end) begin
                        if (is_last) begin
                            ctl_d.state = cfg_retrigger ? ST_ARMED : ST_IDLE;
                            ctl_d.done  = 1'b1;
                            clear       = 1'b1;
                        end else if (!cfg_continuous && !cfg_pause_en) begin
                            ctl_d.pcnt = ctl_q.pcnt + 1'b1;
                        end
                    end
                end
                default: begin
                    ctl_d.state = ST_IDLE;
                    clear       = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.pcnt  <= '0;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = (ctl_q.state == ST_RUN);
    assign done = ctl_q.done;
endmodule

// File: rtl/pgen_checker.sv
module pgen_checker (
    input logic clk,
    input logic rst,
    input logic sw_stop,
    input logic gate,
    input logic cfg_pause_en,
    input logic cfg_pause_pol,
    input logic pulse_out,
    input logic busy,
    input logic done
);
    AST_OUT_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> busy);                                            // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                // R3
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));                               // R3
    AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (rst)
        sw_stop |=> (!busy && !pulse_out));                             // R4
    AST_STOP_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        sw_stop |=> !done);                                             // R4
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_pause_en && (gate != cfg_pause_pol) && !sw_stop)
        |=> (busy && $stable(pulse_out)));                              // R9
endmodule

bind pulse_train_gen pgen_checker u_pgen_checker (
    .clk           (clk),
    .rst           (rst),
    .sw_stop       (sw_stop),
    .gate          (gate),
    .cfg_pause_en  (cfg_pause_en),
    .cfg_pause_pol (cfg_pause_pol),
    .pulse_out     (pulse_out),
    .busy          (busy),
    .done          (done)
);

// File: tb/tb_pulse_train_gen.sv
`timescale 1ns/1ps
module tb_pulse_train_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_arm = 0, hw_arm = 0, gate = 0, sw_stop = 0;
    logic [15:0] cfg_high_ticks = 16'd2, cfg_low_ticks = 16'd3;
    logic [15:0] cfg_pulse_count = 16'd3;
    logic        cfg_continuous = 0, cfg_retrigger = 0, cfg_start_pol = 1;
    logic        cfg_pause_en = 0, cfg_pause_pol = 1;
    logic        pulse_out, busy, done;

    int checks = 0, errors = 0, rises = 0, dones = 0;
    string cur_req = "R1";
    bit finished = 0;

    // behavioural reference state
    int m_state = 0, m_rem = 0, m_left = 0;
    bit m_out = 0, m_done = 0, m_pg = 0, m_pa = 0, last_out = 0;

    always #5 clk = ~clk;

    pulse_train_gen dut (
        .clk(clk), .rst(rst), .sw_arm(sw_arm), .hw_arm(hw_arm), .gate(gate),
        .sw_stop(sw_stop), .cfg_high_ticks(cfg_high_ticks),
        .cfg_low_ticks(cfg_low_ticks), .cfg_pulse_count(cfg_pulse_count),
        .cfg_continuous(cfg_continuous), .cfg_retrigger(cfg_retrigger),
        .cfg_start_pol(cfg_start_pol), .cfg_pause_en(cfg_pause_en),
        .cfg_pause_pol(cfg_pause_pol), .pulse_out(pulse_out), .busy(busy),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch();
        m_state = 2; m_out = 1; m_rem = cfg_high_ticks; m_left = cfg_pulse_count;
    endtask

    always @(posedge clk) begin
        bit arm_e, st_e, paused;
        if (rst) begin
            m_state = 0; m_out = 0; m_done = 0;
        end else begin
            arm_e  = sw_arm || (hw_arm && !m_pa);
            st_e   = (gate == cfg_start_pol) && (gate != m_pg);
            paused = cfg_pause_en && (gate != cfg_pause_pol);
            m_done = 0;
            if (sw_stop) begin
                m_state = 0; m_out = 0;
            end else if (m_state == 0) begin
                if (arm_e) begin
                    if (cfg_pause_en) launch(); else m_state = 1;
                end
            end else if (m_state == 1) begin
                if (cfg_pause_en || st_e) launch();
            end else if (!paused) begin
                m_rem--;
                if (m_rem == 0) begin
                    if (m_out) begin
                        m_out = 0; m_rem = cfg_low_ticks;
                    end else if (!cfg_continuous && !cfg_pause_en) begin
                        m_left--;
                        if (m_left == 0) begin
                            m_done = 1; m_state = cfg_retrigger ? 1 : 0;
                        end else begin
                            m_out = 1; m_rem = cfg_high_ticks;
                        end
                    end else begin
                        m_out = 1; m_rem = cfg_high_ticks;
                    end
                end
            end
        end
        m_pg = gate; m_pa = hw_arm;
        #1;
        if (!finished) begin
            check({pulse_out, busy, done} == {m_out, (m_state == 2), m_done},
                  cur_req, "per-cycle {out,busy,done}",
                  {pulse_out, busy, done}, {m_out, (m_state == 2), m_done});
            if (pulse_out && !last_out) rises++;
            if (done) dones++;
            last_out = pulse_out;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_sw();
        sw_arm = 1; wait_n(1); sw_arm = 0;
    endtask

    task automatic stop_sw();
        sw_stop = 1; wait_n(1); sw_stop = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit held;
        wait_n(3);
        rst = 0;
        wait_n(1);
        check({pulse_out, busy, done} == 3'b000, "R1", "reset state", {pulse_out, busy, done}, 0);

        // R1: start edges while unarmed
        cur_req = "R1";
        gate = 1; wait_n(2); gate = 0; wait_n(3);
        check(busy == 0, "R1", "busy without arm", busy, 0);

        // R2 R3: finite train of 3
        cur_req = "R3";
        arm_sw(); wait_n(2);
        rises = 0; dones = 0;
        gate = 1; wait_n(2); gate = 0;
        wait_n(20);
        check(rises == 3, "R3", "pulse count", rises, 3);
        check(dones == 1, "R3", "done pulses", dones, 1);

        // R6: edges during a run are ignored
        cur_req = "R6";
        arm_sw(); rises = 0;
        gate = 1; wait_n(4); gate = 0; wait_n(2); gate = 1; wait_n(2); gate = 0;
        wait_n(20);
        check(rises == 3, "R6", "pulses with extra edge", rises, 3);

        // R5: retrigger
        cur_req = "R5";
        cfg_retrigger = 1; arm_sw(); rises = 0;
        gate = 1; wait_n(2); gate = 0; wait_n(20);
        gate = 1; wait_n(2); gate = 0; wait_n(20);
        check(rises == 6, "R5", "pulses over two retriggers", rises, 6);
        cfg_retrigger = 0; rises = 0;
        gate = 1; wait_n(2); gate = 0; wait_n(20);
        gate = 1; wait_n(3);
        check(busy == 0, "R5", "edge after non-retrigger finish", busy, 0);
        gate = 0; wait_n(2);
        check(rises == 3, "R5", "pulses last train", rises, 3);

        // R7: falling start edge, hardware arm
        cur_req = "R7";
        cfg_start_pol = 0; gate = 1; wait_n(2);
        hw_arm = 1; wait_n(2);
        gate = 0; wait_n(2);
        check(busy == 1, "R7", "falling start after hw arm", busy, 1);
        wait_n(2); stop_sw(); wait_n(1);
        gate = 1; wait_n(2); gate = 0; wait_n(2);
        check(busy == 0, "R7", "held hw_arm does not rearm", busy, 0);
        hw_arm = 0; cfg_start_pol = 1; wait_n(2);

        // R4: continuous until stop, stop beats arm
        cur_req = "R4";
        cfg_continuous = 1; arm_sw();
        gate = 1; wait_n(40);
        check(busy == 1, "R4", "continuous still running", busy, 1);
        sw_stop = 1; sw_arm = 1; wait_n(1); sw_stop = 0; sw_arm = 0;
        check({busy, pulse_out} == 2'b00, "R4", "stop quiets", {busy, pulse_out}, 0);
        gate = 0; wait_n(2); gate = 1; wait_n(3);
        check(busy == 0, "R4", "unarmed after stop", busy, 0);
        gate = 0; cfg_continuous = 0; wait_n(2);

        // R4 stop midway through a finite train
        arm_sw(); gate = 1; wait_n(4); stop_sw(); gate = 0;
        check(busy == 0, "R4", "finite stopped", busy, 0);
        wait_n(4);

        // R8 R9: pause mode, run level high then low
        cur_req = "R9";
        cfg_pause_en = 1; cfg_pause_pol = 1; gate = 1; cfg_high_ticks = 3;
        arm_sw();
        check(busy == 1, "R8", "arm starts train in pause mode", busy, 1);
        wait_n(11);
        gate = 0; wait_n(1);
        held = pulse_out; wait_n(6);
        check(pulse_out == held, "R9", "output held while paused", pulse_out, held);
        check(busy == 1, "R9", "busy while paused", busy, 1);
        gate = 1; wait_n(13);
        cfg_pause_pol = 0; wait_n(1); held = pulse_out; wait_n(5);
        check(pulse_out == held, "R9", "held with low run level", pulse_out, held);
        gate = 0; wait_n(10);
        stop_sw(); cfg_pause_en = 0; cfg_pause_pol = 1; wait_n(3);

        // R2 boundary: single one-cycle pulse
        cur_req = "R2";
        cfg_high_ticks = 1; cfg_low_ticks = 1; cfg_pulse_count = 1;
        arm_sw(); rises = 0; dones = 0;
        gate = 1; wait_n(1);
        check(pulse_out == 1, "R2", "first high cycle", pulse_out, 1);
        wait_n(1);
        check(pulse_out == 0, "R2", "low after one cycle", pulse_out, 0);
        wait_n(1);
        check(done == 1, "R10", "done after single pulse", done, 1);
        gate = 0; wait_n(4);
        check(rises == 1 && dones == 1, "R3", "single pulse train", rises, 1);

        summary();
    end
endmodule